// File: doc/BRIEF.md
# Configuration Sequencer

This block is the state machine that takes a programmable device from power-up to operation and back again. It holds off until the core, auxiliary and I/O-bank supply-good flags are all true. It then wipes configuration memory and drives the open-drain init line low while it does so. The wipe continues for as long as the active-low program request stays asserted.

When the wipe is finished, the sequencer releases the init line and waits for the line to read high. It then captures the mode pins. Next it takes in configuration frames until an external CRC unit reports its verdict. A good CRC starts a fixed-length start-up sequence that ends in user mode. A bad CRC parks the block in an abort state with init held low.

From user mode, a reconfigure request returns the sequencer to the wipe. A program request after power-on does the same from any state past the supply wait.

Top module: `cfg_sequencer`

## Requirements
- R1: A synchronous reset sets all outputs to 0 and `mode_q` to 0, and places the sequencer in the supply wait.
- R2: The supply wait is left only when `vcore_ok`, `vaux_ok` and `vio_ok` are all 1. On the next edge, `mem_clear` and `init_drive_low` both go to 1.
- R3: With `prog_n` high, the wipe lasts exactly CLEAR_CYCLES cycles (default 16). While `prog_n` is low, the wipe count restarts, so the wipe ends CLEAR_CYCLES cycles after `prog_n` rises.
- R4: After the wipe, `init_drive_low` is 0 and the block waits for `init_in` = 1. In that cycle it captures `mode_pins`, and `mode_q` shows them one edge later. `mode_q` then stays fixed, and is set to 0 whenever the wipe is entered.
- R5: In the frame-load state, a `crc_done` pulse counts only if at least one `frame_valid` cycle occurred in an earlier cycle of that state. An earlier `crc_done` pulse is ignored and the block stays in frame load.
- R6: `crc_done` with `crc_ok` = 1 starts `startup_active` on the next edge. `startup_active` stays 1 for exactly STARTUP_CYCLES cycles (default 8), after which `user_mode` is 1.
- R7: `crc_done` with `crc_ok` = 0 enters the abort state, in which `init_drive_low` = 1 and `mem_clear` = 0. Only `prog_n` = 0 leaves it, entering the wipe on the next edge.
- R8: In user mode, `reconf_req` = 1 or `prog_n` = 0 enters the wipe on the next edge.
- R9: `prog_n` = 0 during init wait, frame load or start-up enters the wipe on the next edge. `prog_n` has no effect in the supply wait.
- R10: At most one of `mem_clear`, `startup_active` and `user_mode` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcore_ok | input | 1 | Core supply good |
| vaux_ok | input | 1 | Auxiliary supply good |
| vio_ok | input | 1 | I/O bank supply good |
| prog_n | input | 1 | Program request, active low |
| init_in | input | 1 | Sensed level of the init line |
| mode_pins | input | MODE_W | Mode pin levels |
| frame_valid | input | 1 | A configuration frame word is presented |
| crc_done | input | 1 | CRC result strobe |
| crc_ok | input | 1 | CRC result, 1 = pass |
| reconf_req | input | 1 | Reconfigure request from user mode |
| init_drive_low | output | 1 | Pull the init line low |
| mem_clear | output | 1 | Configuration memory wipe in progress |
| mode_q | output | MODE_W | Captured mode |
| startup_active | output | 1 | Start-up sequence running |
| user_mode | output | 1 | Device in user mode |

## Verification
Every output is registered from the next state, so any transition shows up at the outputs one edge after the input that causes it. The captured mode is the only other result, and it likewise appears one edge after the capture cycle. The wipe and start-up lengths are measured by sampling on the last cycle of the window and on the first cycle after it: cycle 16 and cycle 17 of the wipe, and cycle 8 and cycle 9 of start-up. Inputs change at the falling edge, and each expectation is sampled at a later falling edge after a known number of rising edges. As a result, every check lands exactly on the cycle where its result is due.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    ST_PWR   = 3'd0,
    ST_CLR   = 3'd1,
    ST_INITW = 3'd2,
    ST_LOAD  = 3'd3,
    ST_STUP  = 3'd4,
    ST_USER  = 3'd5,
    ST_ABORT = 3'd6
  } cfg_state_e;
endpackage

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != {W{1'b1}}) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfgseq_mode_reg.sv
module cfgseq_mode_reg #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  logic [MW-1:0] din,
  output logic [MW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (cap)   q <= din;
  end
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cfgseq_pkg::*;
#(
  parameter int MODE_W         = 3,
  parameter int CLEAR_CYCLES   = 16,
  parameter int STARTUP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vcore_ok,
  input  logic              vaux_ok,
  input  logic              vio_ok,
  input  logic              prog_n,
  input  logic              init_in,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              frame_valid,
  input  logic              crc_done,
  input  logic              crc_ok,
  input  logic              reconf_req,
  output logic              init_drive_low,
  output logic              mem_clear,
  output logic [MODE_W-1:0] mode_q,
  output logic              startup_active,
  output logic              user_mode
);
  localparam int CNT_MAX = (CLEAR_CYCLES > STARTUP_CYCLES) ? CLEAR_CYCLES : STARTUP_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  cfg_state_e       state_q, state_d;
  logic             got_frame_q;
  logic [CNT_W-1:0] cnt;
  logic             restart, clr_done, stup_done, supplies_ok;

  assign supplies_ok = vcore_ok && vaux_ok && vio_ok;
  assign clr_done    = (cnt == CNT_W'(CLEAR_CYCLES - 1));
  assign stup_done   = (cnt == CNT_W'(STARTUP_CYCLES - 1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PWR:   if (supplies_ok) state_d = ST_CLR;
      ST_CLR:   if (prog_n && clr_done) state_d = ST_INITW;
      ST_INITW: begin
        if (!prog_n)      state_d = ST_CLR;
        else if (init_in) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (!prog_n) state_d = ST_CLR;
        else if (crc_done && got_frame_q) state_d = crc_ok ? ST_STUP : ST_ABORT;
      end
      ST_STUP: begin
        if (!prog_n)        state_d = ST_CLR;
        else if (stup_done) state_d = ST_USER;
      end
      ST_USER:  if (!prog_n || reconf_req) state_d = ST_CLR;
      ST_ABORT: if (!prog_n) state_d = ST_CLR;
      default:  state_d = ST_PWR;
    endcase
  end

  assign restart = (state_d != state_q) || (state_q == ST_CLR && !prog_n);

  cfgseq_timer #(.W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt     (cnt)
  );

  cfgseq_mode_reg #(.MW(MODE_W)) mode_i (
    .clk (clk),
    .rst (rst),
    .clr (state_d == ST_CLR),
    .cap (state_q == ST_INITW && state_d == ST_LOAD),
    .din (mode_pins),
    .q   (mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_PWR;
      got_frame_q    <= 1'b0;
      init_drive_low <= 1'b0;
      mem_clear      <= 1'b0;
      startup_active <= 1'b0;
      user_mode      <= 1'b0;
    end else begin
      state_q        <= state_d;
      got_frame_q    <= (state_q == ST_LOAD && state_d == ST_LOAD) && (got_frame_q || frame_valid);
      init_drive_low <= (state_d == ST_CLR) || (state_d == ST_ABORT);
      mem_clear      <= (state_d == ST_CLR);
      startup_active <= (state_d == ST_STUP);
      user_mode      <= (state_d == ST_USER);
    end
  end
endmodule

// File: rtl/cfg_sequencer_chk.sv
module cfg_sequencer_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_n,
  input logic              crc_done,
  input logic              crc_ok,
  input logic              reconf_req,
  input logic              init_drive_low,
  input logic              mem_clear,
  input logic [MODE_W-1:0] mode_q,
  input logic              startup_active,
  input logic              user_mode
);
  a_r10_one_role: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_clear, startup_active, user_mode}));

  a_r9_prog_forces_clear: assert property (@(posedge clk) disable iff (rst)
    (!prog_n && (mem_clear || startup_active || user_mode)) |=> mem_clear);

  a_r8_reconf_clears: assert property (@(posedge clk) disable iff (rst)
    (user_mode && reconf_req) |=> mem_clear);

  a_r7_abort_holds: assert property (@(posedge clk) disable iff (rst)
    (init_drive_low && !mem_clear && prog_n) |=> (init_drive_low && !mem_clear));

  a_r6_startup_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(startup_active) |-> $past(crc_done && crc_ok));

  a_r6_user_after_startup: assert property (@(posedge clk) disable iff (rst)
    $rose(user_mode) |-> $past(startup_active));

  a_r4_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (startup_active && prog_n) |=> $stable(mode_q));
endmodule

bind cfg_sequencer cfg_sequencer_chk #(.MODE_W(MODE_W)) chk_i (.*);

// File: tb/cfg_sequencer_tb_top.sv
module cfg_sequencer_tb_top;
  localparam int MW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic vcore_ok = 0, vaux_ok = 0, vio_ok = 0, prog_n = 1, init_in = 0;
  logic frame_valid = 0, crc_done = 0, crc_ok = 0, reconf_req = 0;
  logic [MW-1:0] mode_pins = '0;
  logic init_drive_low, mem_clear, startup_active, user_mode;
  logic [MW-1:0] mode_q;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cfg_sequencer #(.MODE_W(MW), .CLEAR_CYCLES(16), .STARTUP_CYCLES(8)) dut_i (
    .clk(clk), .rst(rst), .vcore_ok(vcore_ok), .vaux_ok(vaux_ok), .vio_ok(vio_ok),
    .prog_n(prog_n), .init_in(init_in), .mode_pins(mode_pins),
    .frame_valid(frame_valid), .crc_done(crc_done), .crc_ok(crc_ok),
    .reconf_req(reconf_req), .init_drive_low(init_drive_low), .mem_clear(mem_clear),
    .mode_q(mode_q), .startup_active(startup_active), .user_mode(user_mode)
  );

  // stim {vcore,vaux,vio,prog_n,init_in,frame_valid,crc_done,crc_ok,reconf}, cycles, req, expected {init_low,clear,startup,user}
  localparam logic [24:0] VEC [14] = '{
    {9'b110000000, 8'd5,  4'd9, 4'b0000},  // R2 one supply low, R9 prog ignored
    {9'b111100000, 8'd1,  4'd2, 4'b1100},  // R2 wipe starts
    {9'b111100000, 8'd14, 4'd3, 4'b1100},  // R3 still wiping
    {9'b111100000, 8'd1,  4'd3, 4'b1100},  // R3 cycle 16
    {9'b111100000, 8'd1,  4'd3, 4'b0000},  // R3 wipe over
    {9'b111100000, 8'd3,  4'd4, 4'b0000},  // R4 waiting on init
    {9'b111110000, 8'd1,  4'd4, 4'b0000},  // R4 to load
    {9'b111111000, 8'd2,  4'd5, 4'b0000},  // R5 frames
    {9'b111110110, 8'd1,  4'd6, 4'b0010},  // R6 crc pass
    {9'b111110000, 8'd6,  4'd6, 4'b0010},  // R6
    {9'b111110000, 8'd1,  4'd6, 4'b0010},  // R6 cycle 8
    {9'b111110000, 8'd1,  4'd6, 4'b0001},  // R6 user
    {9'b111110000, 8'd4,  4'd6, 4'b0001},  // R6 stays user
    {9'b111110001, 8'd1,  4'd8, 4'b1100}   // R8 reconfigure
  };

  task automatic drive(input logic [8:0] s);
    {vcore_ok, vaux_ok, vio_ok, prog_n, init_in, frame_valid, crc_done, crc_ok, reconf_req} = s;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {init_drive_low, mem_clear, startup_active, user_mode};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s outputs actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input logic [MW-1:0] exp);
    n_run++;
    if (mode_q !== exp) begin
      n_fail++;
      $display("FAIL %s mode actual=%0d expected=%0d", req, mode_q, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    chk_out("R1", 4'b0000);
    chk_mode("R1", '0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      drive(VEC[i][24:16]);
      step(int'(VEC[i][15:8]));
      chk_out($sformatf("R%0d", VEC[i][7:4]), VEC[i][3:0]);
    end

    // R1: reset mid-wipe
    rst = 1'b1; step(2);
    chk_out("R1", 4'b0000);
    chk_mode("R1", '0);
    rst = 1'b0;

    // R3: held program request stretches the wipe
    drive(9'b111000000); step(1);
    chk_out("R3", 4'b1100);
    step(30);
    chk_out("R3", 4'b1100);
    prog_n = 1; step(15);
    chk_out("R3", 4'b1100);
    step(1);
    chk_out("R3", 4'b0000);

    // R4: mode capture and hold
    mode_pins = 3'd5; step(2);
    chk_mode("R4", '0);
    init_in = 1; step(1);
    chk_mode("R4", 3'd5);
    mode_pins = 3'd2; step(3);
    chk_mode("R4", 3'd5);

    // R5: CRC strobe before any frame is ignored
    crc_done = 1; crc_ok = 1; step(1);
    chk_out("R5", 4'b0000);
    crc_done = 0; crc_ok = 0; frame_valid = 1; step(1);
    frame_valid = 0; crc_done = 1; step(1);
    chk_out("R7", 4'b1000);
    crc_done = 0; reconf_req = 1; step(10);
    chk_out("R7", 4'b1000);
    reconf_req = 0; prog_n = 0; step(1);
    chk_out("R7", 4'b1100);
    chk_mode("R4", '0);

    // R9: program request during start-up
    prog_n = 1; mode_pins = 3'd3; step(17);
    chk_mode("R4", 3'd3);
    frame_valid = 1; step(1);
    frame_valid = 0; crc_done = 1; crc_ok = 1; step(1);
    crc_done = 0;
    chk_out("R6", 4'b0010);
    prog_n = 0; step(1);
    chk_out("R9", 4'b1100);

    // R8: program request in user mode
    prog_n = 1; step(17);
    frame_valid = 1; step(1);
    frame_valid = 0; crc_done = 1; step(1);
    crc_done = 0; step(8);
    chk_out("R6", 4'b0001);
    prog_n = 0; step(1);
    chk_out("R8", 4'b1100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule